// File: doc/BRIEF.md
# Multi-Processor Interrupt Level Router

This block gathers 32 level-sensitive hardware interrupt sources and turns them into processor priority-level requests. Every source is tied to a level by a fixed, irregular table. A programmable disable register filters the sources, and that register also holds a global master-disable bit. The surviving requests go to one processor, chosen by software out of up to 16. Any source whose level is 15 is broadcast to every processor as a level-15 flag.

Software works through a small word-addressed register port with 32-bit data. It can read the pending sources, read the disable state, clear disable bits, set disable bits, and read or write the target processor. For each processor the block drives two 16-bit vectors. The masked vector is what interrupts the processor. The unmasked vector shows every pending source's level and is meant for status readback. The block also drives a per-processor broadcast flag and the master-disable flag. The source inputs are sampled on every clock. The outputs are combinational from the registered state.

Top module: `irq_level_router`

## Requirements
- R1: Source bit j maps to level L(j), where L is 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0 for j = 0..31. A source with level 0 never becomes pending and never produces a level.
- R2: The pending register captures the sources with a nonzero level on every clock edge. A full read at word offset 0 returns it, and bit 31 always reads 0.
- R3: A full read at offset 1 returns the disable register ANDed with the writable mask 0xF05DFF80. Bits outside that mask stay set permanently.
- R4: A full write at offset 2 clears the disable bits where the data is 1. A full write at offset 3 sets the disable bits where the data is 1. Both affect only writable bits.
- R5: While disable bit 31 (master disable) is set, `masterOff` is 1 and every masked vector is all zero.
- R6: A full write at offset 4 keeps only the low 4 bits of the data as the target processor. A full read at offset 4 returns the target, zero-extended.
- R7: With the master disable clear, the masked vector of the target processor has bit L(j) set for each pending source j that is not disabled. The masked vectors of all other processors have bits 14..0 at zero.
- R8: The unmasked vector of the target processor has bit L(j) set for each pending source j, whatever the disable bits hold. The unmasked vectors of the other processors have bits 14..0 at zero.
- R9: While any of sources 27..30 is pending, every processor's `bcastL15` is 1 and bit 15 of its unmasked vector is 1. Bit 15 of its masked vector is also 1 unless the master disable is set.
- R10: After reset, pending is 0, the target is 0, the disable register is 0x0FA2007F (so offset 1 reads 0), and all vectors are zero.
- R11: An access with byte enables other than 4'hF has no effect. A write to offsets 0, 1, 5, 6 or 7 has no effect. Reads at offsets 2, 3, 5, 6 and 7, and every partial read, return 0.
- R12: A register write changes the routed outputs starting in the cycle after its accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIrq | input | 32 | Level-sensitive interrupt sources |
| regSel | input | 1 | Register access request this cycle |
| regWr | input | 1 | 1 = write, 0 = read |
| regBe | input | 4 | Byte enables; only 4'hF takes effect |
| regAddr | input | 3 | Word offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data (combinational) |
| routedLvl | output | NCPU*16 | Masked level vectors, processor c at bits c*16+15..c*16 |
| rawLvl | output | NCPU*16 | Unmasked level vectors, same layout |
| bcastL15 | output | NCPU | Level-15 broadcast flag per processor |
| masterOff | output | 1 | Master disable bit |

## Verification
The router is driven with single sources whose levels are unique, shared or zero. It also sees a source that is disabled for good, a pure level-15 source, a dense all-sources pattern, and partial disable masks. These separate table errors from masking errors and from steering errors. The target processor changes between vectors, so a design that steers to a fixed processor, or to every processor, shows up in the vectors of the other processors. The master-disable case and the disabled-source case show whether the masked and unmasked paths are kept apart. Partial-width and out-of-range accesses are checked through readback of the target and disable registers.

// File: rtl/irq_level_router_pkg.sv
package irq_level_router_pkg;

  localparam int NSRC = 32;
  localparam int NLVL = 16;
  localparam logic [31:0] FIXED_DIS = 32'h0FA2007F;
  localparam logic [31:0] WR_MASK = ~FIXED_DIS;
  localparam int MASTER_BIT = 31;

  typedef struct packed {
    logic clrDis;
    logic setDis;
    logic setTgt;
    logic [31:0] data;
  } regStrobe_t;

  function automatic logic [3:0] srcLevel(input int idx);
    case (idx)
      0, 7: srcLevel = 4'd2;
      1, 8: srcLevel = 4'd3;
      2, 9: srcLevel = 4'd5;
      3, 10: srcLevel = 4'd7;
      4, 11, 21: srcLevel = 4'd9;
      5, 12, 22: srcLevel = 4'd11;
      6, 13, 17: srcLevel = 4'd13;
      14, 15: srcLevel = 4'd12;
      16: srcLevel = 4'd6;
      18: srcLevel = 4'd4;
      19: srcLevel = 4'd10;
      20: srcLevel = 4'd8;
      27, 28, 29, 30: srcLevel = 4'd15;
      default: srcLevel = 4'd0;
    endcase
  endfunction

  function automatic logic [31:0] liveSrcMask();
    logic [31:0] m;
    m = '0;
    for (int j = 0; j < NSRC; j++) m[j] = (srcLevel(j) != 4'd0);
    return m;
  endfunction

  function automatic logic [31:0] topSrcMask();
    logic [31:0] m;
    m = '0;
    for (int j = 0; j < NSRC; j++) m[j] = (srcLevel(j) == 4'd15);
    return m;
  endfunction

endpackage

// File: rtl/irq_level_router_ctrl.sv
module irq_level_router_ctrl
  import irq_level_router_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          regSel,
  input  logic          regWr,
  input  logic [3:0]    regBe,
  input  logic [2:0]    regAddr,
  input  logic [31:0]   regWdata,
  input  logic [31:0]   pendQ,
  input  logic [31:0]   disQ,
  input  logic [TW-1:0] tgtQ,
  output regStrobe_t    strobe,
  output logic [31:0]   regRdata
);

  logic fullAcc;
  logic wrAcc;
  logic rdAcc;

  assign fullAcc = regSel && (regBe == 4'hF);
  assign wrAcc   = fullAcc && regWr;
  assign rdAcc   = fullAcc && !regWr;

  always_comb begin
    strobe.clrDis = wrAcc && (regAddr == 3'd2);
    strobe.setDis = wrAcc && (regAddr == 3'd3);
    strobe.setTgt = wrAcc && (regAddr == 3'd4);
    strobe.data   = regWdata;
  end

  always_comb begin
    regRdata = '0;
    if (rdAcc) begin
      case (regAddr)
        3'd0: regRdata = pendQ & ~(32'd1 << MASTER_BIT);
        3'd1: regRdata = disQ & WR_MASK;
        3'd4: regRdata = 32'(tgtQ);
        default: regRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_level_router_dp.sv
module irq_level_router_dp
  import irq_level_router_pkg::*;
#(
  parameter int NCPU = 16,
  parameter int TW = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [31:0]        srcIrq,
  input  regStrobe_t         strobe,
  output logic [31:0]        pendQ,
  output logic [31:0]        disQ,
  output logic [TW-1:0]      tgtQ,
  output logic [NCPU*16-1:0] routedLvl,
  output logic [NCPU*16-1:0] rawLvl,
  output logic [NCPU-1:0]    bcastL15,
  output logic               masterOff
);

  localparam logic [31:0] LIVE = liveSrcMask();
  localparam logic [31:0] TOP  = topSrcMask();

  logic [31:0] wrBits;
  logic [31:0] effPend;
  logic [15:0] maskLv;
  logic [15:0] rawLv;
  logic        bcastOn;

  assign wrBits = strobe.data & WR_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      disQ  <= FIXED_DIS;
      tgtQ  <= '0;
    end else begin
      pendQ <= srcIrq & LIVE;
      if (strobe.clrDis) disQ <= disQ & ~wrBits;
      else if (strobe.setDis) disQ <= disQ | wrBits;
      if (strobe.setTgt) tgtQ <= strobe.data[TW-1:0];
    end
  end

  assign masterOff = disQ[MASTER_BIT];
  assign effPend   = pendQ & ~disQ;
  assign bcastOn   = |(pendQ & TOP);

  always_comb begin
    maskLv = '0;
    rawLv  = '0;
    for (int j = 0; j < NSRC; j++) begin
      if (srcLevel(j) != 4'd0) begin
        if (pendQ[j])   rawLv[srcLevel(j)]  = 1'b1;
        if (effPend[j]) maskLv[srcLevel(j)] = 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic isTgt;
    assign isTgt = (tgtQ == TW'(c));
    assign routedLvl[c*16 +: 16] = masterOff ? 16'd0 :
        ((isTgt ? maskLv : 16'd0) | {bcastOn, 15'd0});
    assign rawLvl[c*16 +: 16] = (isTgt ? rawLv : 16'd0) | {bcastOn, 15'd0};
    assign bcastL15[c] = bcastOn;
  end

endmodule

// File: rtl/irq_level_router.sv
module irq_level_router
  import irq_level_router_pkg::*;
#(
  parameter int NCPU = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [31:0]        srcIrq,
  input  logic               regSel,
  input  logic               regWr,
  input  logic [3:0]         regBe,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  output logic [NCPU*16-1:0] routedLvl,
  output logic [NCPU*16-1:0] rawLvl,
  output logic [NCPU-1:0]    bcastL15,
  output logic               masterOff
);

  localparam int TW = (NCPU > 1) ? $clog2(NCPU) : 1;

  regStrobe_t    strobe;
  logic [31:0]   pendQ;
  logic [31:0]   disQ;
  logic [TW-1:0] tgtQ;

  irq_level_router_ctrl #(.TW(TW)) u_ctrl (
    .regSel(regSel), .regWr(regWr), .regBe(regBe), .regAddr(regAddr),
    .regWdata(regWdata), .pendQ(pendQ), .disQ(disQ), .tgtQ(tgtQ),
    .strobe(strobe), .regRdata(regRdata)
  );

  irq_level_router_dp #(.NCPU(NCPU), .TW(TW)) u_dp (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .strobe(strobe),
    .pendQ(pendQ), .disQ(disQ), .tgtQ(tgtQ),
    .routedLvl(routedLvl), .rawLvl(rawLvl), .bcastL15(bcastL15),
    .masterOff(masterOff)
  );

endmodule

// File: rtl/irq_level_router_chk.sv
module irq_level_router_chk #(
  parameter int NCPU = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [31:0]        srcIrq,
  input logic               regSel,
  input logic               regWr,
  input logic [3:0]         regBe,
  input logic [2:0]         regAddr,
  input logic [31:0]        regWdata,
  input logic [31:0]        regRdata,
  input logic [NCPU*16-1:0] routedLvl,
  input logic [NCPU*16-1:0] rawLvl,
  input logic [NCPU-1:0]    bcastL15,
  input logic               masterOff
);

  logic armed;
  logic anyMasked;
  logic maskNotRaw;
  logic [NCPU-1:0] lowActive;

  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else armed <= 1'b1;
  end

  always_comb begin
    anyMasked  = 1'b0;
    maskNotRaw = 1'b0;
    lowActive  = '0;
    for (int c = 0; c < NCPU; c++) begin
      anyMasked  = anyMasked | (|routedLvl[c*16 +: 16]);
      maskNotRaw = maskNotRaw | (|(routedLvl[c*16 +: 16] & ~rawLvl[c*16 +: 16]));
      lowActive[c] = |rawLvl[c*16 +: 15];
    end
  end

  // R5
  p_master_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    masterOff |-> !anyMasked);

  // R8: masked levels are a subset of unmasked ones
  p_masked_subset_r8: assert property (@(posedge clk) disable iff (!rstN)
    !maskNotRaw);

  // R7: at most one processor receives routed levels
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lowActive));

  // R9
  p_bcast_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (bcastL15 == {NCPU{$past(|srcIrq[30:27])}}));

  // R6
  p_target_width_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && !regWr && regAddr == 3'd4) |-> (regRdata[31:4] == 28'd0));

  // R2
  p_pend_top_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && !regWr && regAddr == 3'd0) |-> !regRdata[31]);

  // R11
  p_partial_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWr && regBe != 4'hF) |=> $stable(masterOff));

  // R4, R12
  p_master_set_r12: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWr && regBe == 4'hF && regAddr == 3'd3 && regWdata[31]) |=> masterOff);

endmodule

bind irq_level_router irq_level_router_chk #(.NCPU(NCPU)) u_chk (
  .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .regSel(regSel), .regWr(regWr),
  .regBe(regBe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
  .routedLvl(routedLvl), .rawLvl(rawLvl), .bcastL15(bcastL15),
  .masterOff(masterOff)
);

// File: tb/test_irq_level_router.sv
module test_irq_level_router;

  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 16;
  localparam int NVEC = 8;

  // {src, target, disable bits to set}
  localparam logic [NVEC-1:0][95:0] VECS = {
    {32'h8000_0000, 32'd4,  32'h0000_0000},
    {32'h7FFF_FFFF, 32'd9,  32'h0000_0000},
    {32'h0004_1000, 32'd7,  32'h8000_0000},
    {32'h0080_0000, 32'd2,  32'h0000_0000},
    {32'h0000_FF00, 32'd15, 32'h0000_0F00},
    {32'h1000_0000, 32'd5,  32'h0000_0000},
    {32'h0000_0001, 32'd3,  32'h0000_0000},
    {32'h0000_0080, 32'd0,  32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] srcIrq = '0;
  logic regSel = 1'b0;
  logic regWr = 1'b0;
  logic [3:0] regBe = 4'h0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [NCPU*16-1:0] routedLvl;
  logic [NCPU*16-1:0] rawLvl;
  logic [NCPU-1:0] bcastL15;
  logic masterOff;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irq_level_router #(.NCPU(NCPU)) i_irq_level_router (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .regSel(regSel), .regWr(regWr),
    .regBe(regBe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .routedLvl(routedLvl), .rawLvl(rawLvl), .bcastL15(bcastL15),
    .masterOff(masterOff)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lvlOf(input int j);
    int t[32] = '{2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,
                  6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0};
    return t[j];
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    regSel = 1'b1; regWr = 1'b1; regAddr = a; regWdata = d; regBe = be;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0; regBe = 4'h0;
  endtask

  task automatic busRead(input logic [2:0] a, input logic [3:0] be, output logic [31:0] d);
    regSel = 1'b1; regWr = 1'b0; regAddr = a; regBe = be;
    #1 d = regRdata;
    regSel = 1'b0; regBe = 4'h0;
  endtask

  task automatic checkRoutes(input string req, input logic [31:0] src,
                             input int tgt, input logic [31:0] disReg);
    logic [31:0] pend;
    logic master, bc;
    pend = '0;
    for (int j = 0; j < 32; j++) pend[j] = src[j] && (lvlOf(j) != 0);
    master = disReg[31];
    bc = |pend[30:27];
    for (int c = 0; c < NCPU; c++) begin
      logic [15:0] em, er;
      em = '0; er = '0;
      for (int j = 0; j < 32; j++) begin
        if (pend[j] && c == tgt) begin
          er[lvlOf(j)] = 1'b1;
          if (!disReg[j]) em[lvlOf(j)] = 1'b1;
        end
      end
      if (bc) begin er[15] = 1'b1; em[15] = 1'b1; end
      if (master) em = '0;
      check({req, " masked"}, 256'(routedLvl[c*16 +: 16]), 256'(em));
      check({req, " unmasked"}, 256'(rawLvl[c*16 +: 16]), 256'(er));
    end
    check({req, " bcast"}, 256'(bcastL15), 256'({NCPU{bc}}));
    check({req, " master"}, 256'(masterOff), 256'(master));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R10: reset state
    busRead(3'd0, 4'hF, rd); check("R10 pending", 256'(rd), 256'(0));
    busRead(3'd1, 4'hF, rd); check("R10 R3 disable", 256'(rd), 256'(0));
    busRead(3'd4, 4'hF, rd); check("R10 target", 256'(rd), 256'(0));
    check("R10 masked", 256'(routedLvl), 256'(0));
    check("R10 unmasked", 256'(rawLvl), 256'(0));
    rstN = 1'b1;

    // R1 R2 R4 R6 R7 R8 R9 R5: vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] src, dset, dreg;
      int tgt;
      src = VECS[v][95:64]; tgt = int'(VECS[v][63:32]); dset = VECS[v][31:0];
      busWrite(3'd2, 32'hFFFF_FFFF, 4'hF);
      busWrite(3'd3, dset, 4'hF);
      busWrite(3'd4, 32'(tgt), 4'hF);
      srcIrq = src;
      @(negedge clk);
      dreg = 32'h0FA2_007F | (dset & 32'hF05D_FF80);
      checkRoutes($sformatf("R7 R8 vec%0d", v), src, tgt, dreg);
      busRead(3'd0, 4'hF, rd);
      check("R1 R2 pending", 256'(rd), 256'(src & 32'h787F_FFFF));
      busRead(3'd1, 4'hF, rd);
      check("R3 R4 disable", 256'(rd), 256'(dset & 32'hF05D_FF80));
    end

    // R6: only low 4 bits kept
    busWrite(3'd4, 32'h0000_0035, 4'hF);
    busRead(3'd4, 4'hF, rd); check("R6 target trunc", 256'(rd), 256'(5));

    // R11: partial write ignored, partial read zero, other offsets
    busWrite(3'd4, 32'h0000_0009, 4'h3);
    busRead(3'd4, 4'hF, rd); check("R11 partial write", 256'(rd), 256'(5));
    busRead(3'd4, 4'h1, rd); check("R11 partial read", 256'(rd), 256'(0));
    busWrite(3'd5, 32'hFFFF_FFFF, 4'hF);
    busWrite(3'd1, 32'hFFFF_FFFF, 4'hF);
    busRead(3'd1, 4'hF, rd); check("R11 offset1 write", 256'(rd), 256'(0));
    busRead(3'd5, 4'hF, rd); check("R11 offset5 read", 256'(rd), 256'(0));
    busRead(3'd2, 4'hF, rd); check("R11 offset2 read", 256'(rd), 256'(0));

    // R12: master disable takes effect the cycle after the write edge
    srcIrq = 32'h0000_0080;
    busWrite(3'd4, 32'd1, 4'hF);
    @(negedge clk);
    check("R12 before", 256'(routedLvl[16 +: 16]), 256'(16'h0004));
    regSel = 1'b1; regWr = 1'b1; regAddr = 3'd3; regWdata = 32'h8000_0000; regBe = 4'hF;
    #1 check("R12 same cycle", 256'(masterOff), 256'(0));
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0; regBe = 4'h0;
    check("R12 R5 after", 256'(routedLvl[16 +: 16]), 256'(0));
    check("R12 R5 masterOff", 256'(masterOff), 256'(1));
    check("R8 unmasked under master", 256'(rawLvl[16 +: 16]), 256'(16'h0004));

    // R9: level-15 deasserts everywhere
    busWrite(3'd2, 32'h8000_0000, 4'hF);
    srcIrq = 32'h4000_0000;
    @(negedge clk); @(negedge clk);
    check("R9 on", 256'(bcastL15), 256'({NCPU{1'b1}}));
    srcIrq = 32'h0;
    @(negedge clk);
    check("R9 off", 256'(bcastL15), 256'(0));
    check("R9 off masked", 256'(routedLvl), 256'(0));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule